// File: doc/BRIEF.md
# Quadrature Counter Channel with Byte-Serial Host Access

This block is a single 24-bit up/down position counter. A quadrature encoder (A/B phases plus an index mark) or a pulse-and-direction source drives it. The inputs pass through a two-stage synchroniser. They are then sampled on a divided filter clock, and a decoder turns each fresh sample into count steps. The decoder supports pulse/direction counting and x1, x2 and x4 quadrature resolution. It flags an illegal transition when both phases change within one sample.

A host reaches the channel over an 8-bit bus through two ports. A data port moves multi-byte values one byte per access, least significant byte first. An internal byte pointer steers each access and advances after every one. A control port accepts command bytes, and bits 7:6 of each byte route it to one of four targets: the load/reset command, the count-mode register, the input/output control register or the index control register. The host cannot write the count directly. It fills a staging (preset) register and then commands a transfer. The count is read by copying it into an output latch and reading that latch byte by byte. The control port returns a status byte.

Top module: `qcc_channel`

## Requirements
- R1: After reset the count, output latch, staging register, prescaler, byte pointer, status byte and all mode fields are zero.
- R2: Bits 7:6 of a control write select the target: 00 load/reset command, 01 count mode, 10 input/output control, 11 index control. A write to one target leaves the others and the byte pointer untouched.
- R3: Every data-port read or write advances the byte pointer, which wraps from byte 2 back to byte 0. A load command with bit 0 set returns the pointer to byte 0.
- R4: A data write stores the byte into the staging register at the pointer position. The count changes only through a load command with bit 1 set, which copies the staging register into the count, or through counting and index events.
- R5: A load command with bit 4 set copies the count into the output latch. The data port's read value is the latch byte at the pointer, least significant byte first. The latch holds its value until the next such command.
- R6: The status byte is {2'b00, UD, E, SIGN, MATCH, CARRY, BORROW}, with BORROW at bit 0. UD is 1 when the last count step went up.
- R7: A load command with bit 2 set clears BORROW, CARRY, MATCH and SIGN together. Bit 3 clears E alone.
- R8: A load command with bit 5 set loads the filter prescaler from staging byte 0. The synchronised inputs are sampled once every prescaler+1 clocks.
- R9: Count mode bits 4:3 select counting: 0 counts rising edges of A in the direction given by B (1 = up). 1 (x1) counts A rising edges. 2 (x2) counts every edge of A. 3 (x4) counts every single-phase edge. In the quadrature modes the step goes up when the new A differs from the previous B.
- R10: A step up from 0xFFFFFF wraps to 0, toggles CARRY and clears SIGN. A step down from 0 wraps to 0xFFFFFF, toggles BORROW and sets SIGN. MATCH sets when a step lands on the staging value.
- R11: In a quadrature mode with inputs enabled, a sample in which A and B both changed sets E and does not change the count.
- R12: In the input/output control register, bit 0 enables the A/B inputs, and with it clear no step is counted. Bits 4:3 route CARRY (0), BORROW (1), MATCH (2) or SIGN (3) to the flag output.
- R13: In the index control register, bit 0 enables the index and bit 1 sets polarity (1 = active high). A sampled index that becomes active loads the staging value into the count when IO control bit 1 is 0, or loads zero when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe (advances pointer) |
| ctrl_wr | input | 1 | Control-port command strobe |
| wdata | input | 8 | Write byte for data or control port |
| rdata | output | 8 | Output latch byte at the byte pointer |
| flags_o | output | 8 | Status byte |
| enc_a | input | 1 | Phase A / count pulse |
| enc_b | input | 1 | Phase B / direction |
| enc_idx | input | 1 | Index mark |
| flg_o | output | 1 | Selected status flag |

## Verification
The bound checker watches several behaviours on every cycle. The pointer must stay in range, advance on each access and clear on command. The count must hold when no fresh sample or command arrives. The latch must capture the count on command. The clear commands must take effect, and a wrap must toggle CARRY. An illegal sample must set E. The bench runs a behavioural model compared every clock on the status byte, read byte and flag output. Only its scenarios show the counting resolutions, the prescaler-dependent sampling, and index loading under each polarity and action. They also show that a mode write leaves the pointer alone and that disabled inputs are ignored.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

    typedef enum logic [1:0] {
        SEL_LOAD  = 2'b00,
        SEL_MODE  = 2'b01,
        SEL_IO    = 2'b10,
        SEL_INDEX = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        SC_PULSE = 2'd0,
        SC_X1    = 2'd1,
        SC_X2    = 2'd2,
        SC_X4    = 2'd3
    } scale_e;

    typedef enum logic [1:0] {
        FO_CARRY  = 2'd0,
        FO_BORROW = 2'd1,
        FO_MATCH  = 2'd2,
        FO_SIGN   = 2'd3
    } flg_sel_e;

    typedef struct packed {
        logic idx;
        logic b;
        logic a;
    } pins_t;

    typedef struct packed {
        logic ud;
        logic e;
        logic sgn;
        logic cmp;
        logic ct;
        logic bt;
    } flags_t;

    typedef struct packed {
        logic step;
        logic up;
        logic illegal;
        logic idx_hit;
    } evt_t;

    // Load/reset command bit positions
    localparam int LD_RST_PTR   = 0;
    localparam int LD_XFER      = 1;
    localparam int LD_CLR_FLAGS = 2;
    localparam int LD_CLR_ERR   = 3;
    localparam int LD_LATCH     = 4;
    localparam int LD_PSC       = 5;

    function automatic logic [7:0] flag_byte(input flags_t f);
        return {2'b00, f};
    endfunction

endpackage

// File: rtl/qcc_sampler.sv
module qcc_sampler
    import qcc_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pins_t            pins_i,
    input  logic [PSC_W-1:0] psc_i,
    output pins_t            cur_o,
    output pins_t            prev_o,
    output logic             fresh_o
);

    pins_t            sync1_q, sync2_q;
    logic [PSC_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            div_q   <= '0;
            cur_o   <= '0;
            prev_o  <= '0;
            fresh_o <= 1'b0;
        end else begin
            sync1_q <= pins_i;
            sync2_q <= sync1_q;
            if (div_q >= psc_i) begin
                div_q   <= '0;
                prev_o  <= cur_o;
                cur_o   <= sync2_q;
                fresh_o <= 1'b1;
            end else begin
                div_q   <= div_q + 1'b1;
                fresh_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/qcc_decoder.sv
module qcc_decoder
    import qcc_pkg::*;
(
    input  pins_t  cur_i,
    input  pins_t  prev_i,
    input  logic   fresh_i,
    input  scale_e scale_i,
    input  logic   ab_en_i,
    input  logic   idx_en_i,
    input  logic   idx_pol_i,
    output evt_t   evt_o
);

    logic da, db;

    always_comb begin
        da    = cur_i.a ^ prev_i.a;
        db    = cur_i.b ^ prev_i.b;
        evt_o = '0;
        if (fresh_i && ab_en_i) begin
            unique case (scale_i)
                SC_PULSE: begin
                    evt_o.step = cur_i.a & ~prev_i.a;
                    evt_o.up   = cur_i.b;
                end
                SC_X1: begin
                    evt_o.step = da & ~db & cur_i.a;
                    evt_o.up   = cur_i.a ^ prev_i.b;
                end
                SC_X2: begin
                    evt_o.step = da & ~db;
                    evt_o.up   = cur_i.a ^ prev_i.b;
                end
                default: begin
                    evt_o.step = da ^ db;
                    evt_o.up   = cur_i.a ^ prev_i.b;
                end
            endcase
            if (scale_i != SC_PULSE) begin
                evt_o.illegal = da & db;
            end
        end
        if (fresh_i && idx_en_i) begin
            evt_o.idx_hit = (cur_i.idx == idx_pol_i) && (prev_i.idx != idx_pol_i);
        end
    end

endmodule

// File: rtl/qcc_channel.sv
module qcc_channel
    import qcc_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic       ctrl_wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] flags_o,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx,
    output logic       flg_o
);

    localparam int NB    = CNT_W / 8;
    localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1;
    localparam int NSLOT = 2 ** PTR_W;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NB - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    reg_sel_e sel;
    logic     ld_cmd, mode_cmd, io_cmd, idx_cmd;

    assign sel      = reg_sel_e'(wdata[7:6]);
    assign ld_cmd   = ctrl_wr && (sel == SEL_LOAD);
    assign mode_cmd = ctrl_wr && (sel == SEL_MODE);
    assign io_cmd   = ctrl_wr && (sel == SEL_IO);
    assign idx_cmd  = ctrl_wr && (sel == SEL_INDEX);

    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       preset_b [NB];
    logic [CNT_W-1:0] preset_w;
    logic [CNT_W-1:0] cnt_q, latch_q, cnt_step;
    logic [PSC_W-1:0] psc_q;
    scale_e           scale_q;
    flg_sel_e         fsel_q;
    logic             ab_en_q, idx_zero_q, idx_en_q, idx_pol_q;
    flags_t           flags_q;
    logic [7:0]       slot [NSLOT];

    pins_t pins, cur, prev;
    logic  fresh;
    evt_t  evt;

    assign pins = {enc_idx, enc_b, enc_a};

    qcc_sampler #(.PSC_W(PSC_W)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .pins_i  (pins),
        .psc_i   (psc_q),
        .cur_o   (cur),
        .prev_o  (prev),
        .fresh_o (fresh)
    );

    qcc_decoder u_decoder (
        .cur_i     (cur),
        .prev_i    (prev),
        .fresh_i   (fresh),
        .scale_i   (scale_q),
        .ab_en_i   (ab_en_q),
        .idx_en_i  (idx_en_q),
        .idx_pol_i (idx_pol_q),
        .evt_o     (evt)
    );

    // Byte pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ld_cmd && wdata[LD_RST_PTR]) begin
            ptr_q <= '0;
        end else if (data_wr || data_rd) begin
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // Staging register, written a byte at a time
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++) preset_b[i] <= '0;
        end else if (data_wr) begin
            for (int i = 0; i < NB; i++) begin
                if (ptr_q == PTR_W'(i)) preset_b[i] <= wdata;
            end
        end
    end

    generate
        for (genvar g = 0; g < NB; g++) begin : g_pw
            assign preset_w[8*g +: 8] = preset_b[g];
        end
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            if (g < NB) begin : g_live
                assign slot[g] = latch_q[8*g +: 8];
            end else begin : g_pad
                assign slot[g] = 8'h00;
            end
        end
    endgenerate

    // Mode registers
    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q    <= SC_PULSE;
            ab_en_q    <= 1'b0;
            idx_zero_q <= 1'b0;
            fsel_q     <= FO_CARRY;
            idx_en_q   <= 1'b0;
            idx_pol_q  <= 1'b0;
        end else begin
            if (mode_cmd) scale_q <= scale_e'(wdata[4:3]);
            if (io_cmd) begin
                ab_en_q    <= wdata[0];
                idx_zero_q <= wdata[1];
                fsel_q     <= flg_sel_e'(wdata[4:3]);
            end
            if (idx_cmd) begin
                idx_en_q  <= wdata[0];
                idx_pol_q <= wdata[1];
            end
        end
    end

    assign cnt_step = evt.up ? cnt_q + 1'b1 : cnt_q - 1'b1;

    // Count, latch, prescaler, status
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            latch_q <= '0;
            psc_q   <= '0;
            flags_q <= '0;
        end else begin
            if (ld_cmd && wdata[LD_LATCH]) latch_q <= cnt_q;
            if (ld_cmd && wdata[LD_PSC])   psc_q   <= PSC_W'(preset_b[0]);

            if (ld_cmd && wdata[LD_XFER]) begin
                cnt_q <= preset_w;
            end else if (evt.idx_hit) begin
                cnt_q <= idx_zero_q ? '0 : preset_w;
            end else if (evt.step) begin
                cnt_q      <= cnt_step;
                flags_q.ud <= evt.up;
                if (evt.up && cnt_q == CNT_MAX) begin
                    flags_q.ct  <= ~flags_q.ct;
                    flags_q.sgn <= 1'b0;
                end
                if (!evt.up && cnt_q == '0) begin
                    flags_q.bt  <= ~flags_q.bt;
                    flags_q.sgn <= 1'b1;
                end
                if (cnt_step == preset_w) flags_q.cmp <= 1'b1;
            end

            if (evt.illegal) flags_q.e <= 1'b1;

            if (ld_cmd && wdata[LD_CLR_FLAGS]) begin
                flags_q.bt  <= 1'b0;
                flags_q.ct  <= 1'b0;
                flags_q.cmp <= 1'b0;
                flags_q.sgn <= 1'b0;
            end
            if (ld_cmd && wdata[LD_CLR_ERR]) flags_q.e <= 1'b0;
        end
    end

    assign rdata   = slot[ptr_q];
    assign flags_o = flag_byte(flags_q);

    always_comb begin
        unique case (fsel_q)
            FO_CARRY:  flg_o = flags_q.ct;
            FO_BORROW: flg_o = flags_q.bt;
            FO_MATCH:  flg_o = flags_q.cmp;
            default:   flg_o = flags_q.sgn;
        endcase
    end

endmodule

// File: rtl/qcc_checker.sv
module qcc_checker #(
    parameter int CNT_W = 24,
    parameter int NB    = 3,
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ctrl_wr,
    input logic             data_wr,
    input logic             data_rd,
    input logic [7:0]       wdata,
    input logic [PTR_W-1:0] ptr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] latch,
    input logic [7:0]       flags,
    input logic             fresh,
    input logic             step,
    input logic             up,
    input logic             illegal,
    input logic             idx_hit
);

    logic ld;
    assign ld = ctrl_wr && (wdata[7:6] == 2'b00);

    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (rst)
        ptr < PTR_W'(NB));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        ld && wdata[0] |=> ptr == '0);

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (data_wr || data_rd) && !ctrl_wr |=>
        ptr == (($past(ptr) == PTR_W'(NB - 1)) ? PTR_W'(0) : $past(ptr) + PTR_W'(1)));

    assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr && !fresh |=> $stable(cnt));

    assert_latch_copy_R5: assert property (@(posedge clk) disable iff (rst)
        ld && wdata[4] |=> latch == $past(cnt));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        flags[7:6] == 2'b00);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ld && wdata[2] |=> flags[3:0] == 4'h0);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ld && wdata[3] |=> !flags[4]);

    assert_carry_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        step && up && (cnt == '1) && !ctrl_wr && !idx_hit |=>
        (cnt == '0) && (flags[1] != $past(flags[1])));

    assert_illegal_err_R11: assert property (@(posedge clk) disable iff (rst)
        illegal && !ctrl_wr |=> flags[4]);

endmodule

bind qcc_channel qcc_checker #(.CNT_W(CNT_W), .NB(NB), .PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (ctrl_wr),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .wdata   (wdata),
    .ptr     (ptr_q),
    .cnt     (cnt_q),
    .latch   (latch_q),
    .flags   (flags_o),
    .fresh   (fresh),
    .step    (evt.step),
    .up      (evt.up),
    .illegal (evt.illegal),
    .idx_hit (evt.idx_hit)
);

// File: tb/qcc_channel_tb.sv
module qcc_channel_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_wr = 1'b0, data_rd = 1'b0, ctrl_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, flags_o;
    logic       enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic       flg_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    qcc_channel u_dut (
        .clk(clk), .rst(rst), .data_wr(data_wr), .data_rd(data_rd),
        .ctrl_wr(ctrl_wr), .wdata(wdata), .rdata(rdata), .flags_o(flags_o),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .flg_o(flg_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit         mdl_ok = 0;
    logic [2:0] m_s1, m_s2, m_cur, m_prev;
    bit         m_new;
    int         m_div, m_psc, m_ptr, m_scale, m_fsel;
    logic [23:0] m_cnt, m_latch;
    logic [7:0] m_pre [3];
    bit m_bt, m_ct, m_cm, m_sg, m_e, m_ud;
    bit m_ab, m_idz, m_iden, m_pol;

    always @(posedge clk) begin
        logic [23:0] pw, nxt;
        bit da, db, stp, up, ill, hit, ld;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_cur = 0; m_prev = 0; m_new = 0;
            m_div = 0; m_psc = 0; m_ptr = 0; m_scale = 0; m_fsel = 0;
            m_cnt = 0; m_latch = 0;
            for (int i = 0; i < 3; i++) m_pre[i] = 0;
            m_bt = 0; m_ct = 0; m_cm = 0; m_sg = 0; m_e = 0; m_ud = 0;
            m_ab = 0; m_idz = 0; m_iden = 0; m_pol = 0;
            mdl_ok = 1;
        end else begin
            pw = {m_pre[2], m_pre[1], m_pre[0]};
            da = m_cur[0] ^ m_prev[0];
            db = m_cur[1] ^ m_prev[1];
            stp = 0; up = 0; ill = 0; hit = 0;
            if (m_new && m_ab) begin
                if (m_scale == 0) begin
                    stp = m_cur[0] && !m_prev[0];
                    up  = m_cur[1];
                end else begin
                    up = m_cur[0] ^ m_prev[1];
                    if (da && db) ill = 1;
                    else if (m_scale == 3) stp = da || db;
                    else if (m_scale == 2) stp = da;
                    else stp = da && m_cur[0];
                end
            end
            if (m_new && m_iden) hit = (m_cur[2] == m_pol) && (m_prev[2] != m_pol);
            // sampler
            if (m_div >= m_psc) begin
                m_div = 0; m_prev = m_cur; m_cur = m_s2; m_new = 1;
            end else begin
                m_div++; m_new = 0;
            end
            m_s2 = m_s1;
            m_s1 = {enc_idx, enc_b, enc_a};
            // host commands and counting
            ld = ctrl_wr && (wdata[7:6] == 2'b00);
            if (ld && wdata[4]) m_latch = m_cnt;
            if (ld && wdata[5]) m_psc = m_pre[0];
            if (ld && wdata[1]) m_cnt = pw;
            else if (hit) m_cnt = m_idz ? 24'h0 : pw;
            else if (stp) begin
                nxt = up ? m_cnt + 1 : m_cnt - 1;
                m_ud = up;
                if (up && m_cnt == 24'hFFFFFF) begin m_ct = !m_ct; m_sg = 0; end
                if (!up && m_cnt == 24'h0) begin m_bt = !m_bt; m_sg = 1; end
                if (nxt == pw) m_cm = 1;
                m_cnt = nxt;
            end
            if (ill) m_e = 1;
            if (ld && wdata[2]) begin m_bt = 0; m_ct = 0; m_cm = 0; m_sg = 0; end
            if (ld && wdata[3]) m_e = 0;
            if (ctrl_wr && wdata[7:6] == 2'b01) m_scale = wdata[4:3];
            if (ctrl_wr && wdata[7:6] == 2'b10) begin
                m_ab = wdata[0]; m_idz = wdata[1]; m_fsel = wdata[4:3];
            end
            if (ctrl_wr && wdata[7:6] == 2'b11) begin
                m_iden = wdata[0]; m_pol = wdata[1];
            end
            if (data_wr) m_pre[m_ptr] = wdata;
            if (ld && wdata[0]) m_ptr = 0;
            else if (data_wr || data_rd) m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
        end
    end

    // every-clock comparison
    always @(negedge clk) begin
        logic [7:0] ef;
        bit efo;
        if (!rst && mdl_ok) begin
            ef = {2'b00, m_ud, m_e, m_sg, m_cm, m_ct, m_bt};
            chk("R6 status byte vs model", {24'h0, flags_o}, {24'h0, ef});
            chk("R5 read byte vs model", {24'h0, rdata}, {24'h0, m_latch[8*m_ptr +: 8]});
            case (m_fsel)
                0: efo = m_ct;
                1: efo = m_bt;
                2: efo = m_cm;
                default: efo = m_sg;
            endcase
            chk("R12 flag output vs model", {31'h0, flg_o}, {31'h0, efo});
        end
    end

    // ---------------- host tasks ----------------
    task automatic ctrl(input logic [7:0] b);
        @(negedge clk); ctrl_wr = 1; wdata = b;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); data_wr = 1; wdata = b;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); v = rdata; data_rd = 1;
        @(negedge clk); data_rd = 0;
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        ctrl(8'h11);
        rd(b0); rd(b1); rd(b2);
        v = {b2, b1, b0};
    endtask

    task automatic set_count(input logic [23:0] v);
        ctrl(8'h01);
        wr(v[7:0]); wr(v[15:8]); wr(v[23:16]);
        ctrl(8'h02);
    endtask

    task automatic ab(input bit a, input bit b);
        @(negedge clk); enc_a = a; enc_b = b;
        repeat (10) @(negedge clk);
    endtask

    task automatic idx_pulse();
        @(negedge clk); enc_idx = 1;
        repeat (10) @(negedge clk);
        enc_idx = 0;
        repeat (10) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] v;
        logic [7:0]  b0, b1, b2;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status after reset", {24'h0, flags_o}, 32'h0);
        read_count(v);
        chk("R1 count after reset", {8'h0, v}, 32'h0);

        // R4 staging alone does not move count, transfer does
        ctrl(8'h01); wr(8'h56); wr(8'h34); wr(8'h12);
        read_count(v);
        chk("R4 count untouched by data writes", {8'h0, v}, 32'h0);
        ctrl(8'h02);
        read_count(v);
        chk("R4 count after transfer", {8'h0, v}, 32'h123456);

        // R3 pointer wrap
        ctrl(8'h01); wr(8'hAA); wr(8'hBB); wr(8'hCC); wr(8'hDD);
        ctrl(8'h02);
        read_count(v);
        chk("R3 pointer wraps to byte 0", {8'h0, v}, 32'hCCBBDD);

        // R2 mode write leaves pointer alone
        ctrl(8'h01); wr(8'h11); ctrl(8'h41); wr(8'h22); wr(8'h33);
        ctrl(8'h02);
        read_count(v);
        chk("R2 mode write keeps pointer", {8'h0, v}, 32'h332211);

        // R5 latch holds old count
        ctrl(8'h11);
        set_count(24'h000100);
        ctrl(8'h01);
        rd(b0); rd(b1); rd(b2);
        chk("R5 latch holds captured count", {8'h0, b2, b1, b0}, 32'h332211);
        read_count(v);
        chk("R5 fresh latch", {8'h0, v}, 32'h000100);

        // R9 resolutions
        ctrl(8'h81);
        ctrl(8'h58);
        ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
        read_count(v);
        chk("R9 x4 up cycle", {8'h0, v}, 32'h000104);
        ctrl(8'h48);
        ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
        read_count(v);
        chk("R9 x1 up cycle", {8'h0, v}, 32'h000105);
        ctrl(8'h50);
        ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
        read_count(v);
        chk("R9 x2 up cycle", {8'h0, v}, 32'h000107);
        ctrl(8'h40);
        ab(0, 1);
        for (int i = 0; i < 3; i++) begin ab(1, 1); ab(0, 1); end
        ab(0, 0);
        for (int i = 0; i < 2; i++) begin ab(1, 0); ab(0, 0); end
        read_count(v);
        chk("R9 pulse/direction", {8'h0, v}, 32'h000108);
        chk("R6 UD low after down", {31'h0, flags_o[5]}, 32'h0);

        // R10 wrap behaviour
        ctrl(8'h58);
        set_count(24'hFFFFFF);
        ab(1, 0);
        chk("R10 carry toggle on overflow", {24'h0, flags_o}, 32'h22);
        chk("R12 flag output routes carry", {31'h0, flg_o}, 32'h1);
        ab(0, 0);
        chk("R10 borrow, sign, match on underflow", {24'h0, flags_o}, 32'h0F);
        read_count(v);
        chk("R10 underflow value", {8'h0, v}, 32'hFFFFFF);
        ctrl(8'h04);
        chk("R7 group clear", {24'h0, flags_o}, 32'h00);

        // R11 illegal transition
        ab(1, 1);
        chk("R11 error flag set", {24'h0, flags_o}, 32'h10);
        read_count(v);
        chk("R11 count unchanged", {8'h0, v}, 32'hFFFFFF);
        ctrl(8'h08);
        chk("R7 error clear", {24'h0, flags_o}, 32'h00);

        // R12 inputs disabled
        ctrl(8'h80);
        ab(0, 1); ab(0, 0);
        read_count(v);
        chk("R12 disabled inputs ignored", {8'h0, v}, 32'hFFFFFF);
        chk("R12 no flags while disabled", {24'h0, flags_o}, 32'h00);
        ctrl(8'h81);

        // R8 prescaler
        ctrl(8'h01); wr(8'h03); ctrl(8'h21);
        ab(1, 0);
        read_count(v);
        chk("R8 counts with prescaler", {8'h0, v}, 32'h000000);
        @(negedge clk); enc_a = 0;
        repeat (3) @(negedge clk);
        chk("R8 not yet sampled", {31'h0, flags_o[0]}, 32'h0);
        repeat (8) @(negedge clk);
        chk("R8 sampled after divide", {31'h0, flags_o[0]}, 32'h1);
        ctrl(8'h01); wr(8'h00); ctrl(8'h21);
        ctrl(8'h0C);

        // R13 index
        ctrl(8'h01); wr(8'h10); wr(8'h00); wr(8'h00);
        ctrl(8'hC3);
        ctrl(8'h81);
        idx_pulse();
        read_count(v);
        chk("R13 index loads staging", {8'h0, v}, 32'h000010);
        ctrl(8'h83);
        idx_pulse();
        read_count(v);
        chk("R13 index clears count", {8'h0, v}, 32'h000000);
        ctrl(8'hC0);

        // R10 match and R12 routing
        ctrl(8'h01); wr(8'h01); wr(8'h00); wr(8'h00);
        ctrl(8'h04);
        ctrl(8'h91);
        ab(1, 0);
        chk("R10 match on landing", {24'h0, flags_o}, 32'h24);
        chk("R12 flag output routes match", {31'h0, flg_o}, 32'h1);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule